// File: doc/BRIEF.md
# Delayed Interrupt Generator

The block raises one of two interrupt lines a programmed number of clock cycles after it is asked to. One line feeds the processor's fast interrupt input and the other its normal interrupt input. Each line has its own one-shot countdown, its own schedule strobe and its own clear strobe. A single delay bus carries the cycle count with any schedule strobe.

When a countdown expires, its line goes high. The line then stays high until a clear strobe, or a schedule with a zero count, pulls it low again. A zero-count schedule never fires. It acts as a quiet cancel: it drops the line and leaves that countdown disarmed.

The command decoder sits upstream, so the block only ever sees strobes and a count. Reset is asserted asynchronously and released synchronously inside the block. Commands should therefore start a few cycles after the reset input goes high.

Top module: `dlyirq_gen`

## Requirements
- R1: After reset both interrupt outputs are low and both countdowns are disarmed, so neither output rises without a schedule strobe.
- R2: A fast-line schedule with a count D greater than zero, sampled at clock edge t, makes `fast_irq_o` high from edge t+D onward. The output is low at every edge before that unless it was already high.
- R3: A normal-line schedule with a count D greater than zero behaves as in R2, on `norm_irq_o`.
- R4: Once an output is high, it stays high until that line receives a clear strobe or a zero-count schedule.
- R5: A schedule with a count of zero drives that line low at the next edge and cancels any pending expiry on it.
- R6: A clear strobe drives its line low at the next edge and cancels any pending expiry on it.
- R7: A clear strobe has priority over a schedule strobe and over an expiry that fall in the same cycle on the same line.
- R8: A schedule on an armed line replaces the pending expiry with the new count. This also holds when the old expiry falls in the same cycle as the new schedule, and in that case the line does not rise.
- R9: A schedule with a nonzero count on a line that is already high leaves the line high.
- R10: The two lines are independent: strobes for one line never change the other line's output or countdown.
- R11: The largest count the delay bus can carry, 2^DELAY_W-1, fires exactly that many cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| fast_sched_i | input | 1 | Schedule strobe for the fast line |
| fast_clr_i | input | 1 | Clear strobe for the fast line |
| norm_sched_i | input | 1 | Schedule strobe for the normal line |
| norm_clr_i | input | 1 | Clear strobe for the normal line |
| delay_i | input | DELAY_W | Count in cycles, shared by both schedule strobes |
| fast_irq_o | output | 1 | Fast interrupt level |
| norm_irq_o | output | 1 | Normal interrupt level |

## Verification
The bench builds the block with DELAY_W set to 10. With that width, the largest count of 1023 can be exercised directly, so R11's full-scale expiry is checked within a short run. Random counts are kept mostly below 40. This makes expiries, re-schedules landing on the exact expiry cycle, and clear-versus-expiry collisions frequent on both lines at once. Every cycle is compared against a model that works from absolute deadlines rather than a down-counter.

// File: rtl/dlyirq_pkg.sv
package dlyirq_pkg;

  // Number of interrupt lines and their index in the per-line vectors.
  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned LINE_FAST = 0;
  localparam int unsigned LINE_NORM = 1;

  // Per-line command after priority resolution.
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'b00,  // nothing requested this cycle
    ACT_DROP  = 2'b01,  // clear strobe: line low, countdown cancelled
    ACT_QUIET = 2'b10,  // zero-count schedule: same effect as a drop
    ACT_LOAD  = 2'b11   // nonzero schedule: (re)load countdown
  } dly_act_e;

endpackage

// File: rtl/dlyirq_rst_sync.sv
module dlyirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dlyirq_cmd.sv
module dlyirq_cmd
  import dlyirq_pkg::*;
#(
  parameter int unsigned DELAY_W = 32
) (
  input  logic               sched_i,
  input  logic               clr_i,
  input  logic [DELAY_W-1:0] delay_i,
  output dly_act_e           act_o
);

  logic count_zero;

  assign count_zero = (delay_i == '0);

  // Clear outranks any schedule on the same line.
  always_comb begin
    act_o = ACT_IDLE;
    if (clr_i) begin
      act_o = ACT_DROP;
    end else if (sched_i && count_zero) begin
      act_o = ACT_QUIET;
    end else if (sched_i) begin
      act_o = ACT_LOAD;
    end
  end

endmodule

// File: rtl/dlyirq_cdown.sv
module dlyirq_cdown
  import dlyirq_pkg::*;
#(
  parameter int unsigned DELAY_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dly_act_e           act_i,
  input  logic [DELAY_W-1:0] delay_i,
  output logic               expire_o
);

  localparam logic [DELAY_W-1:0] ONE = {{(DELAY_W-1){1'b0}}, 1'b1};

  logic [DELAY_W-1:0] cnt_q;
  logic [DELAY_W-1:0] cnt_d;
  logic               cnt_en;
  logic               armed_q;
  logic               armed_d;
  logic               at_end;
  logic               cancel;
  logic               load;

  assign cancel   = (act_i == ACT_DROP) || (act_i == ACT_QUIET);
  assign load     = (act_i == ACT_LOAD);
  assign at_end   = (cnt_q == '0);
  // A new command in the expiry cycle takes the expiry's place.
  assign expire_o = armed_q && at_end && (act_i == ACT_IDLE);

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (cancel) begin
      armed_d = 1'b0;
    end else if (load) begin
      armed_d = 1'b1;
      cnt_d   = delay_i - ONE;
      cnt_en  = 1'b1;
    end else if (armed_q && at_end) begin
      armed_d = 1'b0;
    end else if (armed_q) begin
      cnt_d   = cnt_q - ONE;
      cnt_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dlyirq_lvl.sv
module dlyirq_lvl
  import dlyirq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  dly_act_e act_i,
  input  logic     expire_i,
  output logic     irq_o
);

  logic irq_q;
  logic irq_d;
  logic irq_en;

  always_comb begin
    irq_d  = irq_q;
    irq_en = 1'b0;
    if ((act_i == ACT_DROP) || (act_i == ACT_QUIET)) begin
      irq_d  = 1'b0;
      irq_en = 1'b1;
    end else if (expire_i) begin
      irq_d  = 1'b1;
      irq_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_en) begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/dlyirq_gen.sv
module dlyirq_gen
  import dlyirq_pkg::*;
#(
  parameter int unsigned DELAY_W    = 32,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fast_sched_i,
  input  logic               fast_clr_i,
  input  logic               norm_sched_i,
  input  logic               norm_clr_i,
  input  logic [DELAY_W-1:0] delay_i,
  output logic               fast_irq_o,
  output logic               norm_irq_o
);

  logic                 rst_core_n;
  logic [NUM_LINES-1:0] sched_vec;
  logic [NUM_LINES-1:0] clr_vec;
  logic [NUM_LINES-1:0] chan_expire;
  logic [NUM_LINES-1:0] irq_vec;
  dly_act_e             chan_act [NUM_LINES];

  dlyirq_rst_sync #(
    .STAGES (SYNC_DEPTH)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  always_comb begin
    sched_vec            = '0;
    clr_vec              = '0;
    sched_vec[LINE_FAST] = fast_sched_i;
    sched_vec[LINE_NORM] = norm_sched_i;
    clr_vec[LINE_FAST]   = fast_clr_i;
    clr_vec[LINE_NORM]   = norm_clr_i;
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    dlyirq_cmd #(
      .DELAY_W (DELAY_W)
    ) u_cmd (
      .sched_i (sched_vec[g]),
      .clr_i   (clr_vec[g]),
      .delay_i (delay_i),
      .act_o   (chan_act[g])
    );

    dlyirq_cdown #(
      .DELAY_W (DELAY_W)
    ) u_cdown (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .act_i    (chan_act[g]),
      .delay_i  (delay_i),
      .expire_o (chan_expire[g])
    );

    dlyirq_lvl u_lvl (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .act_i    (chan_act[g]),
      .expire_i (chan_expire[g]),
      .irq_o    (irq_vec[g])
    );
  end

  assign fast_irq_o = irq_vec[LINE_FAST];
  assign norm_irq_o = irq_vec[LINE_NORM];

endmodule

// File: rtl/dlyirq_chk.sv
module dlyirq_chk #(
  parameter int unsigned DELAY_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fast_sched_i,
  input logic               fast_clr_i,
  input logic               norm_sched_i,
  input logic               norm_clr_i,
  input logic [DELAY_W-1:0] delay_i,
  input logic               fast_irq_o,
  input logic               norm_irq_o,
  input logic [1:0]         expire_i
);

  logic dz;
  assign dz = (delay_i == '0);

  // R6
  fast_clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_clr_i |=> !fast_irq_o);
  // R6
  norm_clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    norm_clr_i |=> !norm_irq_o);
  // R5
  fast_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_sched_i && dz) |=> !fast_irq_o);
  // R5
  norm_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_sched_i && dz) |=> !norm_irq_o);
  // R4
  fast_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_irq_o && !fast_clr_i && !(fast_sched_i && dz)) |=> fast_irq_o);
  // R4
  norm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_irq_o && !norm_clr_i && !(norm_sched_i && dz)) |=> norm_irq_o);
  // R2
  fast_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_irq_o) |-> $past(expire_i[0]));
  // R3
  norm_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(norm_irq_o) |-> $past(expire_i[1]));
  // R7
  clear_beats_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(expire_i[0] && fast_clr_i) && !(expire_i[1] && norm_clr_i));

endmodule

bind dlyirq_gen dlyirq_chk #(.DELAY_W(DELAY_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fast_sched_i (fast_sched_i),
  .fast_clr_i   (fast_clr_i),
  .norm_sched_i (norm_sched_i),
  .norm_clr_i   (norm_clr_i),
  .delay_i      (delay_i),
  .fast_irq_o   (fast_irq_o),
  .norm_irq_o   (norm_irq_o),
  .expire_i     (chan_expire)
);

// File: tb/dlyirq_gen_tb.sv
module dlyirq_gen_tb;

  localparam int unsigned DW = 10;
  localparam longint WATCHDOG = 150000;

  logic          clk;
  logic          rst_n;
  logic          fs, fc, ns, nc;
  logic [DW-1:0] dly;
  logic          fast_irq, norm_irq;

  int     n_cmp;
  int     n_bad;
  bit     checking;
  bit     done;
  string  tag;
  longint cyc;

  // deadline-based expectation for each line
  bit     m_line [2];
  bit     m_arm  [2];
  longint m_dl   [2];

  dlyirq_gen #(.DELAY_W(DW)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .fast_sched_i (fs),
    .fast_clr_i   (fc),
    .norm_sched_i (ns),
    .norm_clr_i   (nc),
    .delay_i      (dly),
    .fast_irq_o   (fast_irq),
    .norm_irq_o   (norm_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic void model_step(int k, bit s, bit c, longint d, longint now);
    if (c || (s && d == 0)) begin
      m_line[k] = 1'b0;
      m_arm[k]  = 1'b0;
    end else if (s) begin
      m_arm[k] = 1'b1;
      m_dl[k]  = now + d;
    end else if (m_arm[k] && now == m_dl[k]) begin
      m_line[k] = 1'b1;
      m_arm[k]  = 1'b0;
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0;
      for (int k = 0; k < 2; k++) begin
        m_line[k] = 1'b0;
        m_arm[k]  = 1'b0;
        m_dl[k]   = 0;
      end
    end else begin
      cyc = cyc + 1;
      model_step(0, fs, fc, longint'(dly), cyc);
      model_step(1, ns, nc, longint'(dly), cyc);
    end
  end

  always @(negedge clk) begin
    if (checking && !done) begin
      n_cmp++;
      if (fast_irq !== m_line[0]) begin
        n_bad++;
        $display("FAIL %s fast line cyc=%0d actual=%b expected=%b", tag, cyc, fast_irq, m_line[0]);
      end
      n_cmp++;
      if (norm_irq !== m_line[1]) begin
        n_bad++;
        $display("FAIL %s norm line cyc=%0d actual=%b expected=%b", tag, cyc, norm_irq, m_line[1]);
      end
    end
  end

  task automatic summary();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    summary();
  end

  task automatic drive(bit a, bit b, bit c, bit d, logic [DW-1:0] v);
    @(negedge clk);
    fs = a; fc = b; ns = c; nc = d; dly = v;
    @(negedge clk);
    fs = 0; fc = 0; ns = 0; nc = 0; dly = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; checking = 0; done = 0;
    fs = 0; fc = 0; ns = 0; nc = 0; dly = '0;
    rst_n = 1'b0;
    tag = "R1 reset";
    repeat (3) @(negedge clk);
    checking = 1;
    rst_n = 1'b1;
    idle(20);

    tag = "R2 fast delay 5";       drive(1, 0, 0, 0, 10'd5);   idle(8);
    tag = "R4 fast holds";         idle(10);
    tag = "R6 fast clear";         drive(0, 1, 0, 0, 10'd0);   idle(3);
    tag = "R3 norm delay 1";       drive(0, 0, 1, 0, 10'd1);   idle(4);
    tag = "R5 norm zero sched";    drive(0, 0, 1, 0, 10'd0);   idle(3);
    tag = "R5 zero cancels";       drive(1, 0, 0, 0, 10'd6);   idle(2);
                                   drive(1, 0, 0, 0, 10'd0);   idle(10);
    tag = "R6 clear cancels";      drive(0, 0, 1, 0, 10'd4);   drive(0, 0, 0, 1, 10'd0); idle(8);
    tag = "R8 reschedule longer";  drive(1, 0, 0, 0, 10'd3);   drive(1, 0, 0, 0, 10'd9); idle(12);
    tag = "R6 clear fast";         drive(0, 1, 0, 0, 10'd0);
    tag = "R8 resched on expiry";  drive(0, 0, 1, 0, 10'd2);   drive(0, 0, 1, 0, 10'd7); idle(10);
    tag = "R6 clear norm";         drive(0, 0, 0, 1, 10'd0);
    tag = "R7 clear on expiry";    drive(1, 0, 0, 0, 10'd2);   drive(0, 1, 0, 0, 10'd0); idle(6);
    tag = "R7 clear beats sched";  drive(1, 1, 0, 0, 10'd3);   idle(6);
    tag = "R9 sched while high";   drive(0, 0, 1, 0, 10'd2);   idle(4);
                                   drive(0, 0, 1, 0, 10'd5);   idle(8);
                                   drive(0, 0, 0, 1, 10'd0);
    tag = "R10 independent";       drive(1, 0, 1, 0, 10'd4);   idle(1);
                                   drive(0, 1, 0, 0, 10'd0);   idle(6);
                                   drive(0, 0, 0, 1, 10'd0);
    tag = "R11 max count";         drive(1, 0, 0, 0, 10'd1023); idle(1030);
                                   drive(0, 1, 0, 0, 10'd0);   idle(2);

    tag = "R10 random";
    void'($urandom(32'd4711));
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      fs  = ($urandom % 8) == 0;
      fc  = ($urandom % 20) == 0;
      ns  = ($urandom % 8) == 0;
      nc  = ($urandom % 20) == 0;
      dly = (($urandom % 6) == 0) ? '0 : DW'($urandom % 40);
    end
    @(negedge clk);
    fs = 0; fc = 0; ns = 0; nc = 0; dly = '0;
    idle(50);
    summary();
  end

endmodule